// File: doc/BRIEF.md
# Load/Store Queue Unit

This block keeps memory micro-ops in order from dispatch until they reach memory. Each load is given a slot in a load queue. Each store is given one slot index that selects an entry in two parallel store queues: one holds the store address and the other holds the store data. Execute fills the address and data slots later, by index and in any order. The address and the data of a store arrive on separate ports.

A load goes to the single memory request port as soon as its address is known. When several loads are ready, the oldest goes first. A store is never sent on its own. Commit logic first marks the oldest uncommitted store as committed, and it may do so only once that store holds both its address and its data. Committed stores then drain in order from the head and take the port ahead of any load. A flush discards every load and every store that has not yet committed. Committed stores survive a flush.

Top module: `lsq_unit`

## Requirements
- R1: After reset both queues are empty: no memory request, no dispatch stall, no store ready to commit, and both allocation indices are 0.
- R2: Allocation hands out the tail index of a queue and advances it by one modulo the depth (8 by default). A dispatch that needs only one queue is not held back by the other queue being full.
- R3: `alloc_stall` is high when a requested queue holds 8 entries. While it is high, neither queue allocates.
- R4: A load whose address has been written is offered on the memory port with `mem_req_store`=0 and its own index and address, unless a committed store is waiting.
- R5: Among loads that have an address and have not yet been sent, the one allocated earliest is offered first.
- R6: A load without an address is never offered. A load is sent exactly once, on the cycle when `mem_req_valid` and `mem_req_ready` are both high.
- R7: `st_commit_ready` is high only when the oldest uncommitted store has both its address and its data written.
- R8: A store is offered only after it has committed. Stores go out in allocation order with `mem_req_store`=1, carrying the address and data that were written for them.
- R9: While any committed store is waiting, the port offers that store even when loads are ready.
- R10: `commit_st` is ignored while `st_commit_ready` is low.
- R11: `flush` empties the load queue, removes every uncommitted store and sets the store tail just past the last committed store. Committed stores still drain afterwards. In the flush cycle, allocation, index writes, commit and load issue are all ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop all uncommitted work |
| alloc_ld | input | 1 | Dispatch requests a load slot |
| alloc_st | input | 1 | Dispatch requests a store slot |
| alloc_stall | output | 1 | A requested queue is full |
| alloc_ld_idx | output | IW | Index the next load receives |
| alloc_st_idx | output | IW | Index the next store receives |
| ld_addr_we | input | 1 | Write a load address |
| ld_addr_idx | input | IW | Load slot to write |
| ld_addr | input | AW | Load address |
| st_addr_we | input | 1 | Write a store address |
| st_addr_idx | input | IW | Store slot for the address |
| st_addr | input | AW | Store address |
| st_data_we | input | 1 | Write store data |
| st_data_idx | input | IW | Store slot for the data |
| st_data | input | DW | Store data |
| commit_st | input | 1 | Commit the oldest uncommitted store |
| st_commit_ready | output | 1 | The oldest uncommitted store is complete |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_store | output | 1 | Request is a store |
| mem_req_idx | output | IW | Queue index of the request |
| mem_req_addr | output | AW | Request address |
| mem_req_data | output | DW | Store data, zero for loads |

## Verification
Directed sequences write load addresses out of allocation order. Issue that follows allocation age is then told apart from issue that follows write order or index order. A store with only its address is committed to show that the request is ignored. A committed store and a ready load are offered together to expose which one wins the port. A flush with one committed store and one uncommitted store shows whether the drop stops at the commit boundary. A long random phase then mixes allocation, out-of-order writes, commits, back-pressure and rare flushes. Here the port, the allocation indices and the ready flag are compared every cycle against a reference model in the bench. This reaches wrap-around and full-queue cases that the directed part does not.

// File: rtl/lsq_unit.sv
module lsq_unit #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc_ld,
  input  logic          alloc_st,
  output logic          alloc_stall,
  output logic [IW-1:0] alloc_ld_idx,
  output logic [IW-1:0] alloc_st_idx,
  input  logic          ld_addr_we,
  input  logic [IW-1:0] ld_addr_idx,
  input  logic [AW-1:0] ld_addr,
  input  logic          st_addr_we,
  input  logic [IW-1:0] st_addr_idx,
  input  logic [AW-1:0] st_addr,
  input  logic          st_data_we,
  input  logic [IW-1:0] st_data_idx,
  input  logic [DW-1:0] st_data,
  input  logic          commit_st,
  output logic          st_commit_ready,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_store,
  output logic [IW-1:0] mem_req_idx,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data
);

  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] p, input logic [CW-1:0] k);
    logic [CW:0] s;
    s = (CW+1)'(p) + (CW+1)'(k);
    if (s >= (CW+1)'(DEPTH)) s = s - (CW+1)'(DEPTH);
    return s[IW-1:0];
  endfunction

  logic [IW-1:0]    ld_head, ld_tail, st_head, st_tail;
  logic [CW-1:0]    ld_cnt, st_cnt, st_ncmt;
  logic [DEPTH-1:0] ld_v, ld_av, ld_iss;
  logic [DEPTH-1:0] st_v, st_av, st_dv;
  logic [AW-1:0]    ld_addr_q [DEPTH];
  logic [AW-1:0]    st_addr_q [DEPTH];
  logic [DW-1:0]    st_data_q [DEPTH];

  logic ld_full, st_full, alloc_go, ld_push, st_push, ld_pop, st_pop;
  logic commit_go, st_issue, ld_fire, mem_fire;
  logic ld_pick_ok;
  logic [IW-1:0] ld_pick_idx, st_cidx;

  assign ld_full      = ld_cnt == CW'(DEPTH);
  assign st_full      = st_cnt == CW'(DEPTH);
  assign alloc_stall  = (alloc_ld && ld_full) || (alloc_st && st_full);
  assign alloc_go     = !alloc_stall && !flush;
  assign ld_push      = alloc_go && alloc_ld;
  assign st_push      = alloc_go && alloc_st;
  assign alloc_ld_idx = ld_tail;
  assign alloc_st_idx = st_tail;

  assign st_cidx         = wrap_add(st_head, st_ncmt);
  assign st_commit_ready = (st_cnt > st_ncmt) && st_av[st_cidx] && st_dv[st_cidx];
  assign commit_go       = commit_st && st_commit_ready && !flush;

  always_comb begin
    ld_pick_ok  = 1'b0;
    ld_pick_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] idx;
      idx = wrap_add(ld_head, CW'(k));
      if (!ld_pick_ok && ld_v[idx] && ld_av[idx] && !ld_iss[idx]) begin
        ld_pick_ok  = 1'b1;
        ld_pick_idx = idx;
      end
    end
  end

  assign st_issue      = st_ncmt != '0;
  assign mem_req_valid = st_issue || (ld_pick_ok && !flush);
  assign mem_req_store = st_issue;
  assign mem_req_idx   = st_issue ? st_head : ld_pick_idx;
  assign mem_req_addr  = st_issue ? st_addr_q[st_head] : ld_addr_q[ld_pick_idx];
  assign mem_req_data  = st_issue ? st_data_q[st_head] : '0;
  assign mem_fire      = mem_req_valid && mem_req_ready;
  assign st_pop        = mem_fire && st_issue;
  assign ld_fire       = mem_fire && !st_issue;
  assign ld_pop        = ld_v[ld_head] && ld_iss[ld_head];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_head <= '0;
      ld_tail <= '0;
      ld_cnt  <= '0;
      ld_v    <= '0;
      ld_av   <= '0;
      ld_iss  <= '0;
    end else if (flush) begin
      ld_tail <= ld_head;
      ld_cnt  <= '0;
      ld_v    <= '0;
      ld_av   <= '0;
      ld_iss  <= '0;
    end else begin
      if (ld_pop) begin
        ld_v[ld_head]   <= 1'b0;
        ld_av[ld_head]  <= 1'b0;
        ld_iss[ld_head] <= 1'b0;
        ld_head         <= wrap_add(ld_head, CW'(1));
      end
      if (ld_push) begin
        ld_v[ld_tail]   <= 1'b1;
        ld_av[ld_tail]  <= 1'b0;
        ld_iss[ld_tail] <= 1'b0;
        ld_tail         <= wrap_add(ld_tail, CW'(1));
      end
      if (ld_addr_we && ld_v[ld_addr_idx]) ld_av[ld_addr_idx] <= 1'b1;
      if (ld_fire) ld_iss[ld_pick_idx] <= 1'b1;
      ld_cnt <= ld_cnt + CW'(ld_push) - CW'(ld_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && ld_addr_we && ld_v[ld_addr_idx]) ld_addr_q[ld_addr_idx] <= ld_addr;
    if (!flush && st_addr_we && st_v[st_addr_idx]) st_addr_q[st_addr_idx] <= st_addr;
    if (!flush && st_data_we && st_v[st_data_idx]) st_data_q[st_data_idx] <= st_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_head <= '0;
      st_tail <= '0;
      st_cnt  <= '0;
      st_ncmt <= '0;
      st_v    <= '0;
      st_av   <= '0;
      st_dv   <= '0;
    end else if (flush) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (CW'(k) >= st_ncmt || (k == 0 && st_pop)) begin
          st_v[wrap_add(st_head, CW'(k))]  <= 1'b0;
          st_av[wrap_add(st_head, CW'(k))] <= 1'b0;
          st_dv[wrap_add(st_head, CW'(k))] <= 1'b0;
        end
      end
      st_tail <= wrap_add(st_head, st_ncmt);
      if (st_pop) st_head <= wrap_add(st_head, CW'(1));
      st_ncmt <= st_ncmt - CW'(st_pop);
      st_cnt  <= st_ncmt - CW'(st_pop);
    end else begin
      if (st_pop) begin
        st_v[st_head]  <= 1'b0;
        st_av[st_head] <= 1'b0;
        st_dv[st_head] <= 1'b0;
        st_head        <= wrap_add(st_head, CW'(1));
      end
      if (st_push) begin
        st_v[st_tail]  <= 1'b1;
        st_av[st_tail] <= 1'b0;
        st_dv[st_tail] <= 1'b0;
        st_tail        <= wrap_add(st_tail, CW'(1));
      end
      if (st_addr_we && st_v[st_addr_idx]) st_av[st_addr_idx] <= 1'b1;
      if (st_data_we && st_v[st_data_idx]) st_dv[st_data_idx] <= 1'b1;
      st_ncmt <= st_ncmt + CW'(commit_go) - CW'(st_pop);
      st_cnt  <= st_cnt + CW'(st_push) - CW'(st_pop);
    end
  end

  a_r3_ld_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt <= CW'(DEPTH) && st_cnt <= CW'(DEPTH));

  a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ld && ld_full) |=> ld_cnt <= $past(ld_cnt));

  a_r4_load_has_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_store) |-> (ld_v[mem_req_idx] && ld_av[mem_req_idx] && !ld_iss[mem_req_idx]));

  a_r8_store_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_store) |-> (st_v[st_head] && st_av[st_head] && st_dv[st_head]));

  a_r7_commit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    st_ncmt <= st_cnt);

  a_r9_store_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ncmt != '0) |-> (mem_req_valid && mem_req_store));

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ld_cnt == '0 && st_cnt == st_ncmt));

endmodule

// File: tb/lsq_unit_tb.sv
module lsq_unit_tb;
  localparam int D = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 0, alloc_ld = 0, alloc_st = 0;
  logic ld_addr_we = 0, st_addr_we = 0, st_data_we = 0, commit_st = 0, mem_req_ready = 0;
  logic [IW-1:0] ld_addr_idx = 0, st_addr_idx = 0, st_data_idx = 0;
  logic [31:0] ld_addr = 0, st_addr = 0;
  logic [63:0] st_data = 0;
  logic alloc_stall, st_commit_ready, mem_req_valid, mem_req_store;
  logic [IW-1:0] alloc_ld_idx, alloc_st_idx, mem_req_idx;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_data;

  always #5 clk = ~clk;

  lsq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_ld(alloc_ld), .alloc_st(alloc_st),
    .alloc_stall(alloc_stall), .alloc_ld_idx(alloc_ld_idx), .alloc_st_idx(alloc_st_idx),
    .ld_addr_we(ld_addr_we), .ld_addr_idx(ld_addr_idx), .ld_addr(ld_addr),
    .st_addr_we(st_addr_we), .st_addr_idx(st_addr_idx), .st_addr(st_addr),
    .st_data_we(st_data_we), .st_data_idx(st_data_idx), .st_data(st_data),
    .commit_st(commit_st), .st_commit_ready(st_commit_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_store(mem_req_store),
    .mem_req_idx(mem_req_idx), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data)
  );

  int checks = 0, errors = 0;

  bit m_lv[D], m_lav[D], m_liss[D];
  bit m_sv[D], m_sav[D], m_sdv[D];
  logic [31:0] m_la[D], m_sa[D];
  logic [63:0] m_sd[D];
  int m_lh = 0, m_lt = 0, m_lc = 0, m_sh = 0, m_st = 0, m_sc = 0, m_nc = 0;

  bit e_stall, e_cr, e_mv, e_ms;
  int e_pick, e_midx;
  logic [31:0] e_maddr;
  logic [63:0] e_mdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic predict();
    int c;
    e_stall = (alloc_ld && m_lc == D) || (alloc_st && m_sc == D);
    c = (m_sh + m_nc) % D;
    e_cr = (m_sc > m_nc) && m_sav[c] && m_sdv[c];
    e_pick = -1;
    for (int k = 0; k < D; k++) begin
      int i;
      i = (m_lh + k) % D;
      if (e_pick < 0 && m_lv[i] && m_lav[i] && !m_liss[i]) e_pick = i;
    end
    e_mv = 0; e_ms = 0; e_midx = 0; e_maddr = 0; e_mdata = 0;
    if (m_nc > 0) begin
      e_mv = 1; e_ms = 1; e_midx = m_sh; e_maddr = m_sa[m_sh]; e_mdata = m_sd[m_sh];
    end else if (e_pick >= 0 && !flush) begin
      e_mv = 1; e_midx = e_pick; e_maddr = m_la[e_pick];
    end
  endtask

  task automatic compare();
    predict();
    chk(alloc_stall == e_stall, "R3", "alloc_stall", 64'(alloc_stall), 64'(e_stall));
    chk(alloc_ld_idx == IW'(m_lt) && alloc_st_idx == IW'(m_st), "R2", "alloc idx",
        {alloc_ld_idx, alloc_st_idx}, {IW'(m_lt), IW'(m_st)});
    chk(st_commit_ready == e_cr, "R7", "st_commit_ready", 64'(st_commit_ready), 64'(e_cr));
    chk(mem_req_valid == e_mv, "R4", "mem_req_valid", 64'(mem_req_valid), 64'(e_mv));
    if (e_mv && mem_req_valid) begin
      chk(mem_req_store == e_ms, "R9", "mem_req_store", 64'(mem_req_store), 64'(e_ms));
      chk(mem_req_idx == IW'(e_midx), "R5", "mem_req_idx", 64'(mem_req_idx), 64'(e_midx));
      chk(mem_req_addr == e_maddr, "R5", "mem_req_addr", 64'(mem_req_addr), 64'(e_maddr));
      chk(mem_req_data == e_mdata, "R8", "mem_req_data", mem_req_data, e_mdata);
    end
  endtask

  task automatic update();
    bit fire, spop, lfire, go, cgo, lpop, lwa, swa, sda;
    fire = e_mv && mem_req_ready;
    spop = fire && e_ms;
    lfire = fire && !e_ms;
    go = !e_stall && !flush;
    cgo = commit_st && e_cr && !flush;
    if (flush) begin
      for (int i = 0; i < D; i++) begin m_lv[i] = 0; m_lav[i] = 0; m_liss[i] = 0; end
      m_lt = m_lh; m_lc = 0;
      for (int k = 0; k < D; k++) begin
        int i;
        i = (m_sh + k) % D;
        if (k >= m_nc || (k == 0 && spop)) begin m_sv[i] = 0; m_sav[i] = 0; m_sdv[i] = 0; end
      end
      m_st = (m_sh + m_nc) % D;
      if (spop) begin m_sh = (m_sh + 1) % D; m_nc--; end
      m_sc = m_nc;
    end else begin
      lpop = m_lv[m_lh] && m_liss[m_lh];
      lwa = ld_addr_we && m_lv[ld_addr_idx];
      swa = st_addr_we && m_sv[st_addr_idx];
      sda = st_data_we && m_sv[st_data_idx];
      if (lpop) begin m_lv[m_lh] = 0; m_lav[m_lh] = 0; m_liss[m_lh] = 0; m_lh = (m_lh + 1) % D; end
      if (go && alloc_ld) begin m_lv[m_lt] = 1; m_lav[m_lt] = 0; m_liss[m_lt] = 0; m_lt = (m_lt + 1) % D; end
      if (lwa) begin m_lav[ld_addr_idx] = 1; m_la[ld_addr_idx] = ld_addr; end
      if (lfire) m_liss[e_pick] = 1;
      m_lc = m_lc + ((go && alloc_ld) ? 1 : 0) - (lpop ? 1 : 0);
      if (spop) begin m_sv[m_sh] = 0; m_sav[m_sh] = 0; m_sdv[m_sh] = 0; m_sh = (m_sh + 1) % D; end
      if (go && alloc_st) begin m_sv[m_st] = 1; m_sav[m_st] = 0; m_sdv[m_st] = 0; m_st = (m_st + 1) % D; end
      if (swa) begin m_sav[st_addr_idx] = 1; m_sa[st_addr_idx] = st_addr; end
      if (sda) begin m_sdv[st_data_idx] = 1; m_sd[st_data_idx] = st_data; end
      m_nc = m_nc + (cgo ? 1 : 0) - (spop ? 1 : 0);
      m_sc = m_sc + ((go && alloc_st) ? 1 : 0) - (spop ? 1 : 0);
    end
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; alloc_ld = 0; alloc_st = 0; ld_addr_we = 0; st_addr_we = 0;
    st_data_we = 0; commit_st = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_ed42));
    for (int i = 0; i < D; i++) begin
      m_lv[i] = 0; m_lav[i] = 0; m_liss[i] = 0; m_sv[i] = 0; m_sav[i] = 0; m_sdv[i] = 0;
      m_la[i] = 0; m_sa[i] = 0; m_sd[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(!mem_req_valid && !alloc_stall && !st_commit_ready, "R1", "reset outputs",
        {mem_req_valid, alloc_stall, st_commit_ready}, 0);
    chk(alloc_ld_idx == 0 && alloc_st_idx == 0, "R1", "reset idx", {alloc_ld_idx, alloc_st_idx}, 0);
    step();

    alloc_ld = 1;
    for (int i = 0; i < D; i++) step();
    alloc_st = 1;
    #1 chk(alloc_stall == 1, "R3", "stall on full load queue", 64'(alloc_stall), 1);
    step();
    alloc_ld = 0;
    #1 chk(alloc_stall == 0, "R2", "store-only dispatch with full load queue", 64'(alloc_stall), 0);
    step();
    idle();

    ld_addr_we = 1; ld_addr_idx = 5; ld_addr = 32'h500; step();
    ld_addr_idx = 2; ld_addr = 32'h200; step();
    idle();
    #1 chk(mem_req_valid && mem_req_idx == 2, "R5", "oldest ready load", 64'(mem_req_idx), 2);
    mem_req_ready = 1; step();
    #1 chk(mem_req_valid && mem_req_idx == 5 && mem_req_addr == 32'h500, "R5", "second load",
           64'(mem_req_addr), 64'h500);
    step();
    #1 chk(mem_req_valid == 0, "R6", "no issue without address", 64'(mem_req_valid), 0);
    mem_req_ready = 0;
    flush = 1; step(); idle();
    #1 chk(alloc_ld_idx == 0 && alloc_st_idx == 0, "R11", "tails after flush",
           {alloc_ld_idx, alloc_st_idx}, 0);

    alloc_st = 1; step(); step(); idle();
    st_addr_we = 1; st_addr_idx = 0; st_addr = 32'hA0; step(); idle();
    #1 chk(st_commit_ready == 0, "R7", "address only not ready", 64'(st_commit_ready), 0);
    commit_st = 1; step(); idle();
    #1 chk(mem_req_valid == 0, "R10", "early commit ignored", 64'(mem_req_valid), 0);
    st_data_we = 1; st_data_idx = 0; st_data = 64'hD0; step(); idle();
    #1 chk(st_commit_ready == 1, "R7", "address and data ready", 64'(st_commit_ready), 1);
    alloc_ld = 1; step(); idle();
    ld_addr_we = 1; ld_addr_idx = 0; ld_addr = 32'h300; step(); idle();
    #1 chk(mem_req_valid && !mem_req_store && mem_req_addr == 32'h300, "R4", "load offered",
           64'(mem_req_addr), 64'h300);
    commit_st = 1; step(); idle();
    #1 chk(mem_req_store == 1, "R9", "committed store wins", 64'(mem_req_store), 1);
    chk(mem_req_addr == 32'hA0 && mem_req_data == 64'hD0, "R8", "store payload", mem_req_data, 64'hD0);
    flush = 1; step(); idle();
    #1 chk(alloc_st_idx == 1, "R11", "store tail past committed", 64'(alloc_st_idx), 1);
    chk(mem_req_valid && mem_req_store, "R11", "committed store survives flush", 64'(mem_req_store), 1);
    mem_req_ready = 1; step(); mem_req_ready = 0;
    #1 chk(mem_req_valid == 0, "R11", "loads dropped by flush", 64'(mem_req_valid), 0);

    for (int n = 0; n < 5000; n++) begin
      alloc_ld = ($urandom % 3) == 0;
      alloc_st = ($urandom % 3) == 0;
      ld_addr_we = ($urandom % 2) == 0; ld_addr_idx = IW'($urandom); ld_addr = $urandom;
      st_addr_we = ($urandom % 3) == 0; st_addr_idx = IW'($urandom); st_addr = $urandom;
      st_data_we = ($urandom % 3) == 0; st_data_idx = IW'($urandom); st_data = {$urandom, $urandom};
      commit_st = ($urandom % 3) == 0;
      flush = ($urandom % 60) == 0;
      mem_req_ready = ($urandom % 4) != 0;
      step();
    end
    idle();
    mem_req_ready = 0;
    step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule